// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device side of a serial flash that answers only continuous array reads. It runs from a fast system clock. It resynchronises the serial clock, the active-low select and the serial data input, and detects the serial clock edges. While select is low it collects an 8-bit opcode, a 24-bit address and a run of dummy bits from the serial input, one bit on each rising serial clock edge. It then streams bytes from an internal byte array on the serial output, most significant bit first. The output changes only after falling serial clock edges, so a host using clock mode 0 or mode 3 can sample it on the rising edge.

Two page geometries are supported. The long-page geometry has pages of 264 bytes, and the address holds a page number above a 9-bit byte offset. The short-page geometry has pages of 256 bytes, and the address is linear: a page number above an 8-bit offset. A configuration input picks the geometry for each command. The read address advances once per byte. It moves into the next page without a pause, and it returns to page 0 after the last byte of the last page. A test-only preload port fills the array one byte per clock.

Top module: `flash_rd_responder`

## Requirements
- R1: Opcode 0xE8 is followed by 24 address bits and 32 dummy bits. The first data bit appears on `so` after the falling serial clock edge that follows the 64th rising edge of the command.
- R2: Opcode 0x0B is followed by 24 address bits and 8 dummy bits. The first data bit appears after the falling edge that follows the 40th rising edge.
- R3: When `page_big` is 1 at the last address bit, the long-page geometry applies. Address bits [8:0] are the byte offset, and an offset of 264 or more is reduced by 264. Bits from 9 upward are the page number, taken modulo the page count.
- R4: When `page_big` is 0 at the last address bit, the short-page geometry applies. Address bits [7:0] are the byte offset, and bits from 8 upward are the page number, taken modulo the page count.
- R5: Data bytes leave most significant bit first, from consecutive addresses, with `so_oe` at 1 for every data bit.
- R6: After the last byte of a page (offset 263 or 255), the next byte is offset 0 of the next page, with no extra serial clock cycles.
- R7: After the last byte of the last page, the next byte is page 0, offset 0, with no gap.
- R8: Within 3 system clocks of `cs_n` going high, `so_oe` falls to 0. The next low period of `cs_n` starts a fresh command.
- R9: For an opcode other than 0xE8 or 0x0B, the rest of the select period is ignored and `so_oe` stays 0. The next select period is decoded normally.
- R10: After reset, and throughout the opcode, address and dummy phases, `so_oe` is 0.
- R11: Address bits above the page field are ignored, as are page bits above the implemented page count.
- R12: `so` changes only after a falling serial clock edge. Both serial clock idle levels work: low (mode 0) and high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| page_big | input | 1 | 1 selects 264-byte pages, 0 selects 256-byte pages |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| pl_we | input | 1 | Preload write strobe |
| pl_page | input | PAGE_BITS | Preload page number |
| pl_ofs | input | 9 | Preload byte offset within the long page |
| pl_data | input | 8 | Preload byte |

## Verification
A bit counter that slips makes the first data bit appear one serial clock early or late. The whole stream is then shifted, and this shows on the first compared data bit. A wrong offset decode, or a wrong wrap limit for the page or the array, produces a byte that does not match the preloaded pattern. This shows at the first byte read after the faulty address step, and the reads are placed to cross each boundary within a few bytes. A state left stuck after an abort or an unknown opcode shows as `so_oe` at 1 during a header, or as a garbled first byte in the next select period.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;
    localparam int ADDR_BITS       = 24;
    localparam int CNT_W           = 6;
    localparam logic [7:0] OP_LEGACY = 8'hE8;
    localparam logic [7:0] OP_FAST   = 8'h0B;
    localparam int LEGACY_GAP_BITS = 32;
    localparam int FAST_GAP_BITS   = 8;

    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DUMMY = 3'd2,
        ST_DATA  = 3'd3,
        ST_SKIP  = 3'd4
    } rd_state_e;
endpackage

// File: rtl/spi_front.sv
`timescale 1ns/1ps
// Resynchronises the serial pins and produces one-cycle edge pulses.
module spi_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_hi,
    output logic si_s
);
    typedef struct packed {
        logic k1;
        logic k2;
        logic k3;
        logic c1;
        logic c2;
        logic i1;
        logic i2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.k1 = sck;
        d.k2 = q.k1;
        d.k3 = q.k2;
        d.c1 = cs_n;
        d.c2 = q.c1;
        d.i1 = si;
        d.i2 = q.i1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.c1 <= 1'b1;
            q.c2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = q.k2 & ~q.k3;
    assign sck_fall = ~q.k2 & q.k3;
    assign cs_hi    = q.c2;
    assign si_s     = q.i2;
endmodule

// File: rtl/addr_map.sv
`timescale 1ns/1ps
// Splits a raw 24-bit address into page and in-page offset.
module addr_map #(
    parameter int PAGE_BITS  = 3,
    parameter int BIG_PAGE   = 264,
    parameter int SMALL_PAGE = 256
) (
    input  logic [flash_rd_pkg::ADDR_BITS-1:0] raw,
    input  logic                               big,
    output logic [PAGE_BITS-1:0]               page,
    output logic [$clog2(BIG_PAGE)-1:0]        ofs
);
    localparam int BOFS_BITS = $clog2(BIG_PAGE);
    localparam int SOFS_BITS = $clog2(SMALL_PAGE);
    localparam logic [BOFS_BITS-1:0] BIG_SIZE = BOFS_BITS'(BIG_PAGE);

    logic [BOFS_BITS-1:0] big_raw;

    always_comb begin
        big_raw = raw[BOFS_BITS-1:0];
        if (big) begin
            page = raw[BOFS_BITS +: PAGE_BITS];
            ofs  = (big_raw >= BIG_SIZE) ? big_raw - BIG_SIZE : big_raw;
        end else begin
            page = raw[SOFS_BITS +: PAGE_BITS];
            ofs  = BOFS_BITS'(raw[SOFS_BITS-1:0]);
        end
    end
endmodule

// File: rtl/byte_store.sv
`timescale 1ns/1ps
// Byte array: synchronous preload write, combinational read.
module byte_store #(
    parameter int DEPTH = 2112,
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && widx <= LAST_IDX) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/flash_rd_responder.sv
`timescale 1ns/1ps
module flash_rd_responder
    import flash_rd_pkg::*;
#(
    parameter int PAGE_BITS  = 3,
    parameter int BIG_PAGE   = 264,
    parameter int SMALL_PAGE = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck,
    input  logic                        cs_n,
    input  logic                        si,
    input  logic                        page_big,
    output logic                        so,
    output logic                        so_oe,
    input  logic                        pl_we,
    input  logic [PAGE_BITS-1:0]        pl_page,
    input  logic [$clog2(BIG_PAGE)-1:0] pl_ofs,
    input  logic [7:0]                  pl_data
);
    localparam int PAGES     = 1 << PAGE_BITS;
    localparam int BOFS_BITS = $clog2(BIG_PAGE);
    localparam int DEPTH     = PAGES * BIG_PAGE;
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int SH_W      = ADDR_BITS - 1;
    localparam logic [BOFS_BITS-1:0] BIG_LAST   = BOFS_BITS'(BIG_PAGE - 1);
    localparam logic [BOFS_BITS-1:0] SMALL_LAST = BOFS_BITS'(SMALL_PAGE - 1);
    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] LEG_LAST   = CNT_W'(LEGACY_GAP_BITS - 1);
    localparam logic [CNT_W-1:0] FAST_LAST  = CNT_W'(FAST_GAP_BITS - 1);

    typedef struct packed {
        rd_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [CNT_W-1:0]      gap_last;
        logic [SH_W-1:0]       sh;
        logic                  big;
        logic [PAGE_BITS-1:0]  page;
        logic [BOFS_BITS-1:0]  ofs;
        logic [2:0]            bit_idx;
        logic                  so;
        logic                  so_oe;
    } core_t;

    core_t q, d;

    logic                  sck_rise, sck_fall, cs_hi, si_s;
    logic [7:0]            opcode;
    logic [ADDR_BITS-1:0]  raw_addr;
    logic [PAGE_BITS-1:0]  dec_page;
    logic [BOFS_BITS-1:0]  dec_ofs;
    logic [IDX_W-1:0]      rd_idx, wr_idx;
    logic [7:0]            rd_byte;
    logic [BOFS_BITS-1:0]  page_last;
    logic                  in_data, in_skip;
    logic                  cur_big;
    logic [BOFS_BITS-1:0]  cur_ofs;

    spi_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .si_s     (si_s)
    );

    assign raw_addr = {q.sh, si_s};
    assign opcode   = {q.sh[6:0], si_s};

    addr_map #(
        .PAGE_BITS  (PAGE_BITS),
        .BIG_PAGE   (BIG_PAGE),
        .SMALL_PAGE (SMALL_PAGE)
    ) u_map (
        .raw  (raw_addr),
        .big  (page_big),
        .page (dec_page),
        .ofs  (dec_ofs)
    );

    assign rd_idx = IDX_W'(q.page) * IDX_W'(BIG_PAGE) + IDX_W'(q.ofs);
    assign wr_idx = IDX_W'(pl_page) * IDX_W'(BIG_PAGE) + IDX_W'(pl_ofs);

    byte_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk   (clk),
        .we    (pl_we),
        .widx  (wr_idx),
        .wdata (pl_data),
        .ridx  (rd_idx),
        .rdata (rd_byte)
    );

    assign page_last = q.big ? BIG_LAST : SMALL_LAST;

    always_comb begin
        d = q;
        if (cs_hi) begin
            d.st    = ST_CMD;
            d.cnt   = '0;
            d.so_oe = 1'b0;
        end else if (sck_rise) begin
            case (q.st)
                ST_CMD: begin
                    d.sh  = {q.sh[SH_W-2:0], si_s};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == OP_LAST) begin
                        d.cnt = '0;
                        if (opcode == OP_LEGACY) begin
                            d.st       = ST_ADDR;
                            d.gap_last = LEG_LAST;
                        end else if (opcode == OP_FAST) begin
                            d.st       = ST_ADDR;
                            d.gap_last = FAST_LAST;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR: begin
                    d.sh  = {q.sh[SH_W-2:0], si_s};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == ADDR_LAST) begin
                        d.cnt  = '0;
                        d.st   = ST_DUMMY;
                        d.page = dec_page;
                        d.ofs  = dec_ofs;
                        d.big  = page_big;
                    end
                end
                ST_DUMMY: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == q.gap_last) begin
                        d.cnt     = '0;
                        d.st      = ST_DATA;
                        d.bit_idx = '0;
                    end
                end
                default: ;
            endcase
        end else if (sck_fall && q.st == ST_DATA) begin
            d.so      = rd_byte[3'd7 - q.bit_idx];
            d.so_oe   = 1'b1;
            d.bit_idx = q.bit_idx + 1'b1;
            if (q.bit_idx == 3'd7) begin
                if (q.ofs == page_last) begin
                    d.ofs  = '0;
                    d.page = q.page + 1'b1;
                end else begin
                    d.ofs = q.ofs + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign so      = q.so;
    assign so_oe   = q.so_oe;
    assign in_data = (q.st == ST_DATA);
    assign in_skip = (q.st == ST_SKIP);
    assign cur_big = q.big;
    assign cur_ofs = q.ofs;
endmodule

// File: rtl/flash_rd_checker.sv
`timescale 1ns/1ps
module flash_rd_checker #(
    parameter int BOFS_BITS  = 9,
    parameter int BIG_PAGE   = 264,
    parameter int SMALL_PAGE = 256
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fall,
    input logic                 cs_hi,
    input logic                 so,
    input logic                 so_oe,
    input logic                 in_data,
    input logic                 in_skip,
    input logic                 big,
    input logic [BOFS_BITS-1:0] ofs
);
    localparam logic [BOFS_BITS-1:0] BIG_SIZE   = BOFS_BITS'(BIG_PAGE);
    localparam logic [BOFS_BITS-1:0] SMALL_SIZE = BOFS_BITS'(SMALL_PAGE);

    a_r8_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !so_oe);

    a_r12_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(fall));

    a_r10_oe_starts_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(fall && in_data));

    a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_skip |-> !so_oe);

    a_r6_ofs_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> (ofs < (big ? BIG_SIZE : SMALL_SIZE)));
endmodule

bind flash_rd_responder flash_rd_checker #(
    .BOFS_BITS  (BOFS_BITS),
    .BIG_PAGE   (BIG_PAGE),
    .SMALL_PAGE (SMALL_PAGE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall    (sck_fall),
    .cs_hi   (cs_hi),
    .so      (so),
    .so_oe   (so_oe),
    .in_data (in_data),
    .in_skip (in_skip),
    .big     (cur_big),
    .ofs     (cur_ofs)
);

// File: tb/flash_rd_responder_test.sv
`timescale 1ns/1ps
module flash_rd_responder_test;
    localparam int PB    = 3;
    localparam int PAGES = 1 << PB;
    localparam int BIG   = 264;
    localparam int SMALL = 256;
    localparam int DEPTH = PAGES * BIG;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic page_big = 1'b1;
    logic pl_we = 1'b0;
    logic [PB-1:0] pl_page = '0;
    logic [8:0] pl_ofs = '0;
    logic [7:0] pl_data = '0;
    logic so, so_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] mdl [DEPTH];

    always #2.5 clk = ~clk;

    flash_rd_responder #(.PAGE_BITS(PB), .BIG_PAGE(BIG), .SMALL_PAGE(SMALL)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .page_big(page_big), .so(so), .so_oe(so_oe), .pl_we(pl_we),
        .pl_page(pl_page), .pl_ofs(pl_ofs), .pl_data(pl_data)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so_s, output logic oe_s);
        sck = 1'b0;
        si  = b;
        tick(HALF);
        so_s = so;
        oe_s = so_oe;
        sck = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, input string tag);
        logic s, o;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(v[i], s, o);
            chk(tag, int'(o), 0);
        end
    endtask

    function automatic void decode(input int a, input bit big, output int pg, output int of);
        if (big) begin
            pg = (a >> 9) % PAGES;
            of = (a & 511) % BIG;
        end else begin
            pg = (a >> 8) % PAGES;
            of = a & 255;
        end
    endfunction

    task automatic expect_bytes(input int pg0, input int of0, input bit big,
                                input int n, input string tag);
        int pg, of;
        logic [7:0] b;
        logic s, o;
        pg = pg0;
        of = of0;
        for (int k = 0; k < n; k++) begin
            b = mdl[pg * BIG + of];
            for (int i = 7; i >= 0; i--) begin
                spi_bit(1'b0, s, o);
                chk({tag, " oe"}, int'(o), 1);
                chk({tag, " bit"}, int'(s), int'(b[i]));
            end
            of++;
            if (of == (big ? BIG : SMALL)) begin
                of = 0;
                pg = (pg + 1) % PAGES;
            end
        end
    endtask

    task automatic start_cmd(input logic [7:0] op, input int a, input bit big, input bit mode3);
        page_big = big;
        sck = mode3;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        send_byte(op, "R10 opcode");
        send_byte(8'((a >> 16) & 255), "R10 addr");
        send_byte(8'((a >> 8) & 255), "R10 addr");
        send_byte(8'(a & 255), "R10 addr");
    endtask

    task automatic end_cmd(input bit mode3);
        sck = mode3;
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
        chk("R8 oe after select high", int'(so_oe), 0);
    endtask

    task automatic read_cmd(input logic [7:0] op, input int a, input bit big,
                            input bit mode3, input int n, input string tag);
        int pg, of;
        start_cmd(op, a, big, mode3);
        for (int k = 0; k < ((op == 8'hE8) ? 4 : 1); k++) begin
            send_byte(8'hA5, "R10 dummy");
        end
        decode(a, big, pg, of);
        expect_bytes(pg, of, big, n, tag);
        end_cmd(mode3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic s, o;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk("R10 reset oe", int'(so_oe), 0);

        for (int i = 0; i < DEPTH; i++) begin
            mdl[i]  = 8'((i * 37 + (i >> 8) * 11 + 5) & 255);
            pl_we   = 1'b1;
            pl_page = PB'(i / BIG);
            pl_ofs  = 9'(i % BIG);
            pl_data = mdl[i];
            tick(1);
        end
        pl_we = 1'b0;
        tick(2);

        // R1 R3 R5: legacy opcode, long pages, page 2 offset 5
        read_cmd(8'hE8, (2 << 9) | 5, 1'b1, 1'b0, 4, "R1/R3/R5");
        // R2 R4 R6: fast opcode, short pages, crossing into page 2
        read_cmd(8'h0B, (1 << 8) | 250, 1'b0, 1'b0, 10, "R2/R4/R6");
        // R7 R6: long pages, end of array wraps to page 0
        read_cmd(8'h0B, (7 << 9) | 262, 1'b1, 1'b0, 4, "R7 long");
        // R7: short pages wrap
        read_cmd(8'hE8, (7 << 8) | 254, 1'b0, 1'b0, 4, "R7 short");
        // R3 R11: offset 300 folds to 36, high address bits set
        read_cmd(8'h0B, (6'h3F << 18) | (9'h1FB << 9) | 300, 1'b1, 1'b0, 3, "R3/R11");
        // R4 R11: high bits set in short-page geometry
        read_cmd(8'h0B, (7'h7F << 17) | (9'h1FD << 8) | 17, 1'b0, 1'b0, 3, "R4/R11");

        // R9: unknown opcode keeps output off
        sck = 1'b0;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        send_byte(8'h5A, "R9 opcode");
        for (int k = 0; k < 6; k++) send_byte(8'hFF, "R9 ignored");
        end_cmd(1'b0);
        read_cmd(8'hE8, (3 << 9) | 40, 1'b1, 1'b0, 2, "R9 recovery");

        // R12: mode 3, serial clock idles high
        read_cmd(8'hE8, (4 << 9) | 100, 1'b1, 1'b1, 4, "R12 mode3");
        read_cmd(8'h0B, (5 << 8) | 255, 1'b0, 1'b1, 3, "R12/R6 mode3");

        // R8: abort in the middle of a byte
        start_cmd(8'h0B, (1 << 9) | 7, 1'b1, 1'b0);
        send_byte(8'h00, "R10 dummy");
        for (int i = 0; i < 3; i++) begin
            spi_bit(1'b0, s, o);
            chk("R8 data before abort oe", int'(o), 1);
        end
        end_cmd(1'b0);
        read_cmd(8'h0B, (2 << 9) | 9, 1'b1, 1'b0, 2, "R8 fresh command");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule